// File: doc/BRIEF.md
# Receive FIFO with Threshold and Timeout Interrupt

This block sits behind a serial deserializer in a UART receive path. Each received byte is pushed into a 16-entry first-in first-out store. The host drains the store through a read port, and the oldest byte is always visible on the read-data output. The host is interrupted at a fill threshold chosen in software, so that one service can collect a batch of characters instead of taking one interrupt per byte.

A low threshold gives the host a long time to respond before data is lost. A high threshold gives fewer interrupts. A few bytes can sit below the threshold with nobody reading them. To cover that case, a timer counts baud ticks while the store holds data. It raises a timeout interrupt after four character times with no traffic in either direction.

A byte that arrives when every entry is occupied is thrown away, and a sticky overrun flag is set. A control write selects the threshold and can empty the store in one step.

Top module: `rx_fifo_intr`

## Requirements
- R1: The store keeps up to 16 bytes in arrival order. `rdData` always shows the oldest stored byte, and a read (`rdEn` while not empty) removes it. `rxCount` reports the number of stored bytes.
- R2: A control write (`cfgWr` high) loads the 2-bit threshold code `cfgTrig`. The codes mean: 2'b00 = 1 byte, 2'b01 = 4 bytes, 2'b10 = 8 bytes, 2'b11 = 14 bytes. After reset the code is 2'b00.
- R3: `rxIrq` is high whenever `rxCount` is at or above the selected threshold. This level source drops as soon as reads bring the count below the threshold.
- R4: While the store is not empty, `baudTick` pulses are counted. The 40th pulse (4 characters of 10 bit times) with no push and no read since the last such event sets `rxTimeoutIrq`, which also drives `rxIrq`. Any push or read restarts the count.
- R5: A read clears `rxTimeoutIrq` on the following cycle.
- R6: A byte offered while the store holds 16 bytes and no read occurs is discarded. The stored contents stay unchanged and `overrun` is set.
- R7: `overrun` stays set until a cycle with `lsrRead` high clears it. If a new overrun happens in the same cycle as `lsrRead`, the flag stays set.
- R8: A control write with `cfgFlush` high empties the store, resets the timeout count and clears both interrupt sources in one cycle. A byte offered in that same cycle is discarded without setting `overrun`.
- R9: A read and an incoming byte in the same cycle leave `rxCount` unchanged, including when the store is full. This case is not an overrun.
- R10: A read while the store is empty has no effect: `rxCount` stays 0.
- R11: After reset, `rxCount` is 0 and `rxIrq`, `rxTimeoutIrq` and `overrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxValid | input | 1 | A received byte is offered this cycle |
| rxData | input | 8 | The received byte |
| baudTick | input | 1 | One pulse per serial bit period |
| rdEn | input | 1 | Host reads the oldest byte |
| rdData | output | 8 | Oldest stored byte |
| rxCount | output | 5 | Number of stored bytes |
| cfgWr | input | 1 | Control register write strobe |
| cfgTrig | input | 2 | Threshold code loaded by `cfgWr` |
| cfgFlush | input | 1 | Empty the store when written with `cfgWr` |
| lsrRead | input | 1 | Host reads line status; clears `overrun` |
| rxIrq | output | 1 | Receive interrupt (threshold or timeout) |
| rxTimeoutIrq | output | 1 | Timeout source of the receive interrupt |
| overrun | output | 1 | Sticky lost-byte flag |

## Verification
The assertions take the host strobes as single-cycle, clean levels sampled at the clock edge. They also take `baudTick` as a plain pulse train that carries no meaning while the store is empty. The stimulus changes every input only at the falling edge and drops each strobe after one cycle. Baud pulses are sent only in the timeout scenarios, so the threshold sweeps run with the timer idle and the level source alone sets `rxIrq`.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;
  // Strobes from the control side to the storage side
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } fifoStrb_t;
endpackage

// File: rtl/rx_fifo_store.sv
module rx_fifo_store
  import rx_fifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrb_t         strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (strb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.push) wrPtr <= wrPtr + PTR_W'(1);
      if (strb.pop)  rdPtr <= rdPtr + PTR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrPtr] <= wrData;
  end

  assign rdData = mem[rdPtr];
endmodule

// File: rtl/rx_fifo_ctrl.sv
module rx_fifo_ctrl
  import rx_fifo_pkg::*;
#(
  parameter int DEPTH          = 16,
  parameter int TICKS_PER_CHAR = 10,
  parameter int TIMEOUT_CHARS  = 4,
  localparam int CNT_W         = $clog2(DEPTH + 1),
  localparam int TMO_TICKS     = TICKS_PER_CHAR * TIMEOUT_CHARS,
  localparam int TMO_W         = $clog2(TMO_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxValid,
  input  logic             rdEn,
  input  logic             baudTick,
  input  logic             cfgWr,
  input  logic [1:0]       cfgTrig,
  input  logic             cfgFlush,
  input  logic             lsrRead,
  output fifoStrb_t        strb,
  output logic [CNT_W-1:0] count,
  output logic             irqLevel,
  output logic             irqTimeout,
  output logic             overrun
);
  logic [1:0]       trigCode;
  logic [CNT_W-1:0] trigThresh;
  logic [TMO_W-1:0] tmoCnt;
  logic             dropped;
  logic             restart;
  logic             isEmpty;

  // Thresholds scale with depth: 1, quarter, half, two short of full
  always_comb begin
    unique case (trigCode)
      2'b00:   trigThresh = CNT_W'(1);
      2'b01:   trigThresh = CNT_W'(DEPTH / 4);
      2'b10:   trigThresh = CNT_W'(DEPTH / 2);
      default: trigThresh = CNT_W'(DEPTH - 2);
    endcase
  end

  assign isEmpty = (count == '0);

  always_comb begin
    strb.flush = cfgWr && cfgFlush;
    strb.pop   = rdEn && !isEmpty && !strb.flush;
    strb.push  = rxValid && !strb.flush &&
                 ((count != CNT_W'(DEPTH)) || strb.pop);
    dropped    = rxValid && !strb.flush && !strb.push;
    restart    = strb.flush || strb.push || strb.pop;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) trigCode <= 2'b00;
    else if (cfgWr) trigCode <= cfgTrig;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) count <= '0;
    else if (strb.flush) count <= '0;
    else count <= count + CNT_W'(strb.push) - CNT_W'(strb.pop);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) overrun <= 1'b0;
    else if (dropped) overrun <= 1'b1;
    else if (lsrRead) overrun <= 1'b0;
  end

  // Idle timer: runs only with data waiting and no traffic
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmoCnt     <= '0;
      irqTimeout <= 1'b0;
    end else begin
      if (restart || isEmpty) tmoCnt <= '0;
      else if (baudTick && tmoCnt != TMO_W'(TMO_TICKS)) tmoCnt <= tmoCnt + TMO_W'(1);

      if (strb.flush || strb.pop) irqTimeout <= 1'b0;
      else if (!restart && !isEmpty && baudTick &&
               tmoCnt == TMO_W'(TMO_TICKS - 1)) irqTimeout <= 1'b1;
    end
  end

  assign irqLevel = (count >= trigThresh);
endmodule

// File: rtl/rx_fifo_intr.sv
module rx_fifo_intr
  import rx_fifo_pkg::*;
#(
  parameter int DEPTH          = 16,
  parameter int DATA_W         = 8,
  parameter int TICKS_PER_CHAR = 10,
  parameter int TIMEOUT_CHARS  = 4,
  localparam int CNT_W         = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic              baudTick,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  rxCount,
  input  logic              cfgWr,
  input  logic [1:0]        cfgTrig,
  input  logic              cfgFlush,
  input  logic              lsrRead,
  output logic              rxIrq,
  output logic              rxTimeoutIrq,
  output logic              overrun
);
  fifoStrb_t strb;
  logic      irqLevel;
  logic      irqTimeout;

  rx_fifo_ctrl #(
    .DEPTH(DEPTH), .TICKS_PER_CHAR(TICKS_PER_CHAR), .TIMEOUT_CHARS(TIMEOUT_CHARS)
  ) ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rdEn(rdEn), .baudTick(baudTick),
    .cfgWr(cfgWr), .cfgTrig(cfgTrig), .cfgFlush(cfgFlush), .lsrRead(lsrRead),
    .strb(strb), .count(rxCount), .irqLevel(irqLevel), .irqTimeout(irqTimeout),
    .overrun(overrun)
  );

  rx_fifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) store (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(rxData), .rdData(rdData)
  );

  assign rxIrq        = irqLevel || irqTimeout;
  assign rxTimeoutIrq = irqTimeout;
endmodule

// File: rtl/rx_fifo_intr_chk.sv
module rx_fifo_intr_chk
  import rx_fifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             rxValid,
  input logic             rdEn,
  input logic             cfgWr,
  input logic             cfgFlush,
  input logic             lsrRead,
  input fifoStrb_t        strb,
  input logic [CNT_W-1:0] count,
  input logic             rxIrq,
  input logic             rxTimeoutIrq,
  input logic             overrun
);
  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  assert_tmo_needs_data_R4: assert property (@(posedge clk) disable iff (!rstN)
    rxTimeoutIrq |-> count != '0);

  assert_tmo_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |=> !rxTimeoutIrq);

  assert_overrun_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && count == CNT_W'(DEPTH) && !rdEn && !(cfgWr && cfgFlush) |=> overrun);

  assert_overrun_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    overrun && !lsrRead |=> overrun);

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr && cfgFlush |=> count == '0 && !rxIrq);

  assert_rdwr_count_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.push && strb.pop |=> $stable(count));

  assert_empty_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && count == '0 && !rxValid |=> count == '0);
endmodule

bind rx_fifo_intr rx_fifo_intr_chk #(.DEPTH(DEPTH)) chk (
  .clk(clk), .rstN(rstN), .rxValid(rxValid), .rdEn(rdEn), .cfgWr(cfgWr),
  .cfgFlush(cfgFlush), .lsrRead(lsrRead), .strb(strb), .count(rxCount),
  .rxIrq(rxIrq), .rxTimeoutIrq(rxTimeoutIrq), .overrun(overrun)
);

// File: tb/tb_rx_fifo_intr.sv
`timescale 1ns/1ps
module tb_rx_fifo_intr;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxValid = 1'b0, baudTick = 1'b0, rdEn = 1'b0;
  logic [7:0] rxData = '0;
  logic [7:0] rdData;
  logic [4:0] rxCount;
  logic       cfgWr = 1'b0, cfgFlush = 1'b0, lsrRead = 1'b0;
  logic [1:0] cfgTrig = 2'b00;
  logic       rxIrq, rxTimeoutIrq, overrun;

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  logic [7:0] q[$];
  logic expOvr = 1'b0;

  always #2.5 clk = ~clk;

  rx_fifo_intr dut (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData), .baudTick(baudTick),
    .rdEn(rdEn), .rdData(rdData), .rxCount(rxCount), .cfgWr(cfgWr), .cfgTrig(cfgTrig),
    .cfgFlush(cfgFlush), .lsrRead(lsrRead), .rxIrq(rxIrq), .rxTimeoutIrq(rxTimeoutIrq),
    .overrun(overrun)
  );

  function automatic int thrOf(input int code);
    case (code)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // One cycle of traffic; model updated from the requirements
  task automatic step(input logic v, input logic [7:0] d, input logic r,
                      input logic t, input string req);
    logic willPop, willPush;
    rxValid = v; rxData = d; rdEn = r; baudTick = t;
    willPop  = r && q.size() != 0;
    willPush = v && (q.size() < 16 || willPop);
    if (willPop) chk({req, " rdData"}, int'(rdData), int'(q[0]));
    @(posedge clk);
    if (willPop) q.delete(0);
    if (willPush) q.push_back(d);
    if (v && !willPush) expOvr = 1'b1;
    @(negedge clk);
    rxValid = 0; rdEn = 0; baudTick = 0;
    chk({req, " count"}, int'(rxCount), q.size());
    chk({req, " overrun"}, int'(overrun), int'(expOvr));
  endtask

  task automatic cfg(input logic [1:0] code, input logic fl);
    cfgWr = 1; cfgTrig = code; cfgFlush = fl;
    @(posedge clk);
    if (fl) q.delete();
    @(negedge clk);
    cfgWr = 0; cfgFlush = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 1, "R4 tick");
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 count", rxCount, 0);
    chk("R11 rxIrq", rxIrq, 0);
    chk("R11 timeout", rxTimeoutIrq, 0);
    chk("R11 overrun", overrun, 0);
    // R2 default code 00 = 1 byte: one push raises level irq
    step(1, 8'hA5, 0, 0, "R2 default");
    chk("R2 default threshold", rxIrq, 1);
    cfg(2'b00, 1);

    // R1 R2 R3 sweep: every code, every fill level up and down
    for (int code = 0; code < 4; code++) begin
      cfg(code[1:0], 1);
      for (int k = 1; k <= 16; k++) begin
        step(1, 8'((code * 16 + k) * 7), 0, 0, "R1 fill");
        chk($sformatf("R3 rise code%0d k%0d", code, k), rxIrq, int'(k >= thrOf(code)));
      end
      for (int k = 15; k >= 0; k--) begin
        step(0, 8'h00, 1, 0, "R1 drain");
        chk($sformatf("R3 fall code%0d k%0d", code, k), rxIrq, int'(k >= thrOf(code)));
      end
    end

    // R10 read while empty
    step(0, 8'h00, 1, 0, "R10 empty read");
    chk("R10 irq", rxIrq, 0);

    // R6 overrun when full; contents intact
    cfg(2'b11, 1);
    for (int k = 0; k < 16; k++) step(1, 8'(8'h40 + k), 0, 0, "R6 fill");
    step(1, 8'hEE, 0, 0, "R6 overflow");
    chk("R6 overrun", overrun, 1);
    // R9 read+write at full: count stays 16, no further overrun trigger
    step(1, 8'h77, 1, 0, "R9 full rdwr");
    chk("R9 count", rxCount, 16);
    // R7 sticky, then cleared by status read
    for (int k = 0; k < 16; k++) step(0, 8'h00, 1, 0, "R7 drain data");
    chk("R7 sticky", overrun, 1);
    lsrRead = 1; @(posedge clk); expOvr = 0; @(negedge clk); lsrRead = 0;
    chk("R7 cleared", overrun, 0);
    // R7 set wins over simultaneous clear
    for (int k = 0; k < 16; k++) step(1, 8'(k), 0, 0, "R7 refill");
    rxValid = 1; rxData = 8'h99; lsrRead = 1;
    @(posedge clk); @(negedge clk);
    rxValid = 0; lsrRead = 0;
    chk("R7 set wins", overrun, 1);
    lsrRead = 1; @(posedge clk); expOvr = 0; @(negedge clk); lsrRead = 0;
    // R9 read+write mid-level
    cfg(2'b11, 1);
    step(1, 8'h11, 0, 0, "R9 pre");
    step(1, 8'h22, 0, 0, "R9 pre");
    step(1, 8'h33, 1, 0, "R9 mid rdwr");
    chk("R9 mid count", rxCount, 2);

    // R4 timeout after 40 idle baud ticks, threshold 14 so level is quiet
    cfg(2'b11, 1);
    for (int k = 0; k < 3; k++) step(1, 8'(k + 1), 0, 0, "R4 load");
    ticks(39);
    chk("R4 not yet", rxTimeoutIrq, 0);
    ticks(1);
    chk("R4 fired", rxTimeoutIrq, 1);
    chk("R4 rxIrq", rxIrq, 1);
    // R5 read clears it
    step(0, 8'h00, 1, 0, "R5 read");
    chk("R5 cleared", rxTimeoutIrq, 0);
    chk("R5 rxIrq", rxIrq, 0);
    // R4 push restarts the window
    ticks(20);
    step(1, 8'h55, 0, 0, "R4 restart push");
    ticks(39);
    chk("R4 restart not yet", rxTimeoutIrq, 0);
    ticks(1);
    chk("R4 restart fired", rxTimeoutIrq, 1);

    // R8 flush with a byte offered the same cycle
    cfgWr = 1; cfgTrig = 2'b00; cfgFlush = 1; rxValid = 1; rxData = 8'hC3;
    @(posedge clk); q.delete(); @(negedge clk);
    cfgWr = 0; cfgFlush = 0; rxValid = 0;
    chk("R8 count", rxCount, 0);
    chk("R8 rxIrq", rxIrq, 0);
    chk("R8 timeout", rxTimeoutIrq, 0);
    chk("R8 no overrun", overrun, 0);
    step(1, 8'h5A, 0, 0, "R8 after");
    ticks(39);
    chk("R8 timer reset", rxTimeoutIrq, 0);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule